// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block is the hazard controller of a five-stage integer pipeline in which branches and jumps are resolved in the decode stage. It is purely combinational. From the instruction in decode it sees the taken-redirect flag, its two source register indices and its class (conditional branch, register-indirect jump). From the instruction in execute it sees the memory-read flag, the write enable and the destination index. From the instruction in the memory stage it sees whether it is a load and its destination index. From these it drives four pipeline controls: hold the program counter, hold the fetch/decode register, flush the fetch/decode register, and flush the decode/execute register so that a bubble enters execute.

There are three reasons to stall. The first is the classic load-use case, where a load in execute feeds any instruction in decode. The second is a control-flow instruction in decode that needs an operand still being computed in execute. Decode-stage operand forwarding only draws from the memory and write-back stages, so that operand cannot reach decode yet. The third is a control-flow instruction that needs the result of a load that is still in the memory stage. Every stall holds the PC and the fetch/decode register and inserts one bubble. A taken redirect costs one bubble, because only the fetched instruction is discarded. A stall always wins over a redirect in the same cycle, because the redirect was decided on operands that were not yet valid.

Top module: `hazard_unit`

## Requirements
- R1: When no stall cause and no taken redirect is present, pcStall, ifStall, ifFlush and idFlush are all 0.
- R2: A taken redirect (idJumpTaken=1) with no stall cause sets ifFlush=1 and keeps pcStall, ifStall and idFlush at 0.
- R3: When exMemRead=1 and exRd equals idRs1 or idRs2, pcStall, ifStall and idFlush are all 1 and ifFlush is 0, whatever the decode instruction class.
- R4: A destination index of 0 (exRd or memRd) never causes a stall, even when it equals a source index.
- R5: A conditional branch (idIsBranch=1) whose idRs1 or idRs2 equals a nonzero exRd with exRegWrite=1 stalls (pcStall=ifStall=idFlush=1). The same holds for a register-indirect jump (idIsJalr=1) through idRs1.
- R6: A register-indirect jump that is not also a branch uses only idRs1: a match of idRs2 against exRd (exMemRead=0) or memRd causes no stall.
- R7: A branch or register-indirect jump whose needed source equals a nonzero memRd with memIsLoad=1 stalls. With memIsLoad=0 the memory stage causes no stall.
- R8: When any stall cause is present, ifFlush is 0 even if idJumpTaken=1.
- R9: An instruction in decode that is neither branch nor register-indirect jump is not stalled by a producer in execute with exMemRead=0, nor by any load in memory. A control-flow instruction is not stalled by an execute producer with exRegWrite=0 and exMemRead=0.
- R10: pcStall, ifStall and idFlush are always equal to each other, and ifFlush is never 1 together with them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idJumpTaken | input | 1 | Decode resolved a taken branch or jump |
| idIsBranch | input | 1 | Decode holds a conditional branch (reads both sources) |
| idIsJalr | input | 1 | Decode holds a register-indirect jump (reads source 1) |
| idRs1 | input | REG_IDX_W | Decode source register 1 index |
| idRs2 | input | REG_IDX_W | Decode source register 2 index |
| exMemRead | input | 1 | Instruction in execute reads memory |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| exRd | input | REG_IDX_W | Destination index of the instruction in execute |
| memIsLoad | input | 1 | Instruction in the memory stage is a load |
| memRd | input | REG_IDX_W | Destination index of the instruction in memory |
| pcStall | output | 1 | Hold the program counter |
| ifStall | output | 1 | Hold the fetch/decode register |
| ifFlush | output | 1 | Clear the fetch/decode register |
| idFlush | output | 1 | Clear the decode/execute register (bubble) |

## Verification
The bench uses the default five-bit register index and two sources per instruction. Random register indices are drawn from the range 0 to 3 only. This makes matches between decode sources and later-stage destinations frequent, index 0 turns up often, and a redirect regularly coincides with a stall. Directed cases add each single-source match, the register-indirect jump's unused second source, and the memory stage with and without a load.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  localparam int SRC_COUNT = 2;

  // Strobes raised by the comparison datapath toward the control
  typedef struct packed {
    logic loadUse;       // load in execute feeds a decode source
    logic ctlExDep;      // control-flow operand produced in execute
    logic ctlMemLoadDep; // control-flow operand is a load in memory
    logic redirect;      // decode resolved a taken redirect
  } hazardStrobes_t;

endpackage

// File: rtl/hazard_match.sv
module hazard_match
  import hazard_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int NUM_SRC   = 2
) (
  input  logic [NUM_SRC-1:0][REG_IDX_W-1:0] srcIdx,
  input  logic [NUM_SRC-1:0]                ctlNeeds,
  input  logic                              exMemRead,
  input  logic                              exRegWrite,
  input  logic [REG_IDX_W-1:0]              exRd,
  input  logic                              memIsLoad,
  input  logic [REG_IDX_W-1:0]              memRd,
  input  logic                              jumpTaken,
  output hazardStrobes_t                    strobes
);

  localparam logic [REG_IDX_W-1:0] NULL_IDX = '0;

  logic               exLive;
  logic               memLive;
  logic [NUM_SRC-1:0] exHit;
  logic [NUM_SRC-1:0] memHit;

  assign exLive  = (exRd != NULL_IDX);
  assign memLive = (memRd != NULL_IDX);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign exHit[g]  = exLive  && (srcIdx[g] == exRd);
    assign memHit[g] = memLive && (srcIdx[g] == memRd);
  end

  always_comb begin
    strobes               = '0;
    strobes.loadUse       = exMemRead && (|exHit);
    strobes.ctlExDep      = exRegWrite && (|(exHit & ctlNeeds));
    strobes.ctlMemLoadDep = memIsLoad && (|(memHit & ctlNeeds));
    strobes.redirect      = jumpTaken;
  end

  // R4: register 0 never raises a stall strobe
  always_comb begin
    if (exRd == NULL_IDX)
      a_r4_zero_ex_quiet: assert (!strobes.loadUse && !strobes.ctlExDep);
    if (memRd == NULL_IDX)
      a_r4_zero_mem_quiet: assert (!strobes.ctlMemLoadDep);
  end

  // R9: no control-flow need means no control-flow strobe
  always_comb begin
    if (ctlNeeds == '0)
      a_r9_plain_no_ctl_dep: assert (!strobes.ctlExDep && !strobes.ctlMemLoadDep);
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
(
  input  hazardStrobes_t strobes,
  output logic           pcStall,
  output logic           ifStall,
  output logic           ifFlush,
  output logic           idFlush
);

  logic anyStall;

  assign anyStall = strobes.loadUse | strobes.ctlExDep | strobes.ctlMemLoadDep;

  always_comb begin
    pcStall = 1'b0;
    ifStall = 1'b0;
    ifFlush = 1'b0;
    idFlush = 1'b0;
    if (anyStall) begin
      pcStall = 1'b1;
      ifStall = 1'b1;
      idFlush = 1'b1;
    end else if (strobes.redirect) begin
      ifFlush = 1'b1;
    end
  end

  always_comb begin
    // R10: the three stall-side controls move together
    a_r10_stall_trio_equal: assert ((pcStall == ifStall) && (ifStall == idFlush));
    // R10: fetch flush never accompanies a stall
    a_r10_flush_exclusive: assert (!(ifFlush && pcStall));
    // R8: a stall cause suppresses the redirect flush
    if (strobes.loadUse || strobes.ctlExDep || strobes.ctlMemLoadDep)
      a_r8_stall_beats_flush: assert (!ifFlush && pcStall);
    // R1: nothing raised means every control low
    if (strobes == '0)
      a_r1_all_quiet: assert (!pcStall && !ifStall && !ifFlush && !idFlush);
    // R2: redirect alone flushes fetch only
    if (strobes.redirect && !strobes.loadUse && !strobes.ctlExDep && !strobes.ctlMemLoadDep)
      a_r2_redirect_flush_only: assert (ifFlush && !idFlush);
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 idJumpTaken,
  input  logic                 idIsBranch,
  input  logic                 idIsJalr,
  input  logic [REG_IDX_W-1:0] idRs1,
  input  logic [REG_IDX_W-1:0] idRs2,
  input  logic                 exMemRead,
  input  logic                 exRegWrite,
  input  logic [REG_IDX_W-1:0] exRd,
  input  logic                 memIsLoad,
  input  logic [REG_IDX_W-1:0] memRd,
  output logic                 pcStall,
  output logic                 ifStall,
  output logic                 ifFlush,
  output logic                 idFlush
);

  logic [SRC_COUNT-1:0][REG_IDX_W-1:0] srcIdx;
  logic [SRC_COUNT-1:0]                ctlNeeds;
  hazardStrobes_t                      strobes;

  assign srcIdx   = {idRs2, idRs1};
  // Source 1 feeds both branch compare and indirect target; source 2 only the compare
  assign ctlNeeds = {idIsBranch, idIsBranch | idIsJalr};

  hazard_match #(
    .REG_IDX_W (REG_IDX_W),
    .NUM_SRC   (SRC_COUNT)
  ) i_match (
    .srcIdx     (srcIdx),
    .ctlNeeds   (ctlNeeds),
    .exMemRead  (exMemRead),
    .exRegWrite (exRegWrite),
    .exRd       (exRd),
    .memIsLoad  (memIsLoad),
    .memRd      (memRd),
    .jumpTaken  (idJumpTaken),
    .strobes    (strobes)
  );

  hazard_ctrl i_ctrl (
    .strobes (strobes),
    .pcStall (pcStall),
    .ifStall (ifStall),
    .ifFlush (ifFlush),
    .idFlush (idFlush)
  );

endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;

  localparam int W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic         idJumpTaken, idIsBranch, idIsJalr;
  logic [W-1:0] idRs1, idRs2, exRd, memRd;
  logic         exMemRead, exRegWrite, memIsLoad;
  logic         pcStall, ifStall, ifFlush, idFlush;

  int checks = 0;
  int errors = 0;

  hazard_unit #(.REG_IDX_W(W)) i_hazard_unit (
    .idJumpTaken(idJumpTaken), .idIsBranch(idIsBranch), .idIsJalr(idIsJalr),
    .idRs1(idRs1), .idRs2(idRs2),
    .exMemRead(exMemRead), .exRegWrite(exRegWrite), .exRd(exRd),
    .memIsLoad(memIsLoad), .memRd(memRd),
    .pcStall(pcStall), .ifStall(ifStall), .ifFlush(ifFlush), .idFlush(idFlush)
  );

  // Expected {pcStall, ifStall, ifFlush, idFlush} from the requirements
  function automatic logic [3:0] expect_ctl();
    logic need1, need2, loadUse, exDep, memDep, stall;
    need1   = idIsBranch | idIsJalr;
    need2   = idIsBranch;
    loadUse = exMemRead && exRd != 0 && (exRd == idRs1 || exRd == idRs2);
    exDep   = exRegWrite && exRd != 0 &&
              ((need1 && exRd == idRs1) || (need2 && exRd == idRs2));
    memDep  = memIsLoad && memRd != 0 &&
              ((need1 && memRd == idRs1) || (need2 && memRd == idRs2));
    stall   = loadUse | exDep | memDep;
    return {stall, stall, !stall && idJumpTaken, stall};
  endfunction

  task automatic drive(input logic jt, input logic br, input logic jr,
                       input logic [W-1:0] r1, input logic [W-1:0] r2,
                       input logic emr, input logic erw, input logic [W-1:0] erd,
                       input logic mld, input logic [W-1:0] mrd);
    @(negedge clk);
    idJumpTaken = jt; idIsBranch = br; idIsJalr = jr;
    idRs1 = r1; idRs2 = r2;
    exMemRead = emr; exRegWrite = erw; exRd = erd;
    memIsLoad = mld; memRd = mrd;
    #1;
  endtask

  task automatic check(input string tag);
    logic [3:0] exp, act;
    exp = expect_ctl();
    act = {pcStall, ifStall, ifFlush, idFlush};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pcStall,ifStall,ifFlush,idFlush} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_val(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pcStall, ifStall, ifFlush, idFlush};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pcStall,ifStall,ifFlush,idFlush} actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idJumpTaken = 0; idIsBranch = 0; idIsJalr = 0; idRs1 = 0; idRs2 = 0;
    exMemRead = 0; exRegWrite = 0; exRd = 0; memIsLoad = 0; memRd = 0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    drive(0,0,0, 5'd0,5'd0, 0,0,5'd0, 0,5'd0);  check_val("R1", 4'b0000);
    drive(0,0,0, 5'd3,5'd4, 0,1,5'd7, 0,5'd8);  check_val("R1", 4'b0000);
    // R2: redirect flushes fetch only
    drive(1,1,0, 5'd3,5'd4, 0,0,5'd0, 0,5'd0);  check_val("R2", 4'b0010);
    // R3: load-use on each source, also for plain instruction
    drive(0,0,0, 5'd5,5'd6, 1,1,5'd5, 0,5'd0);  check_val("R3", 4'b1101);
    drive(0,0,0, 5'd5,5'd6, 1,1,5'd6, 0,5'd0);  check_val("R3", 4'b1101);
    // R4: index zero ignored
    drive(0,1,0, 5'd0,5'd0, 1,1,5'd0, 1,5'd0);  check_val("R4", 4'b0000);
    // R5: branch on EX writer, JALR base on EX writer
    drive(0,1,0, 5'd2,5'd9, 0,1,5'd9, 0,5'd0);  check_val("R5", 4'b1101);
    drive(0,0,1, 5'd9,5'd1, 0,1,5'd9, 0,5'd0);  check_val("R5", 4'b1101);
    // R6: JALR ignores source 2
    drive(0,0,1, 5'd1,5'd9, 0,1,5'd9, 0,5'd0);  check_val("R6", 4'b0000);
    drive(0,0,1, 5'd1,5'd9, 0,0,5'd0, 1,5'd9);  check_val("R6", 4'b0000);
    // R7: load in MEM vs non-load in MEM
    drive(0,1,0, 5'd4,5'd11, 0,0,5'd0, 1,5'd11); check_val("R7", 4'b1101);
    drive(0,1,0, 5'd4,5'd11, 0,0,5'd0, 0,5'd11); check_val("R7", 4'b0000);
    // R8: stall beats redirect
    drive(1,1,0, 5'd12,5'd3, 0,1,5'd12, 0,5'd0); check_val("R8", 4'b1101);
    drive(1,0,1, 5'd12,5'd3, 0,0,5'd0, 1,5'd12); check_val("R8", 4'b1101);
    // R9: plain instruction with EX ALU producer and MEM load; no write enable
    drive(0,0,0, 5'd7,5'd8, 0,1,5'd7, 1,5'd8);  check_val("R9", 4'b0000);
    drive(0,1,0, 5'd7,5'd8, 0,0,5'd7, 0,5'd0);  check_val("R9", 4'b0000);

    // Random sweep, small index range for frequent matches (R10 trio via R3/R5/R7/R8)
    for (int i = 0; i < 400; i++) begin
      logic jt, br, jr, emr, erw, mld;
      logic [W-1:0] r1, r2, erd, mrd;
      string tag;
      jt = 1'($urandom); br = 1'($urandom); jr = 1'($urandom);
      emr = 1'($urandom); erw = 1'($urandom); mld = 1'($urandom);
      r1 = W'($urandom_range(0, 3)); r2 = W'($urandom_range(0, 3));
      erd = W'($urandom_range(0, 3)); mrd = W'($urandom_range(0, 3));
      drive(jt, br, jr, r1, r2, emr, erw, erd, mld, mrd);
      if (pcStall !== ifStall || ifStall !== idFlush || (ifFlush && pcStall)) begin
        checks++;
        errors++;
        $display("FAIL R10: actual %b%b%b%b expected trio equal, flush exclusive",
                 pcStall, ifStall, ifFlush, idFlush);
      end
      tag = (expect_ctl() == 4'b0000) ? "R1/R9" :
            (expect_ctl() == 4'b0010) ? "R2" :
            jt ? "R8" : "R3/R5/R7";
      check(tag);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule